// File: doc/BRIEF.md
# Banked GPIO Register Front End

This block is the register side of a 128-pin general-purpose I/O controller, split into four banks of 32 pins. Software reaches it over a simple synchronous bus: one request per cycle, a byte offset that is word aligned, and a write flag. The block holds, for each bank, a direction word, an output latch, rising- and falling-edge enable words and two alternate-function select words. It drives the pad output values and output enables. A level read merges the output latch of output pins with the sampled input of input pins.

Edge-status storage and interrupt generation belong to a companion block. This block feeds that companion with the edge enables, and passes software clears to it as a one-cycle bit mask. It also reads the companion's status back onto the bus. Banks 0 to 2 sit next to each other in the map. Bank 3 sits 0x100 above its bank-0 counterpart, except for the alternate-function words, which are packed together low in the map.

Top module: `gpio_bank_regs`

## Requirements
- R1: After reset every register is zero: all pins are inputs, pad_out, pad_oe, rise_en, fall_en, alt_sel and edge_clr are zero, and every register reads back as zero.
- R2: The direction word of bank b is at offset 0x00C+4b for b<3 and at 0x10C for bank 3. It is read/write, and a 1 bit makes that pin an output (pad_oe bit set).
- R3: A write to the output-set word (0x018+4b, bank 3 at 0x118) ORs the data into that bank's output latch. A write to the output-clear word (0x024+4b, bank 3 at 0x124) clears the latch bits where the data has ones. pad_out equals latch AND direction.
- R4: A read of the level word (0x000+4b, bank 3 at 0x100) returns, per pin, the latch bit if the pin is an output and the registered pad_in bit if it is an input.
- R5: Every level read raises lvl_rd_pulse for exactly the one cycle in which its data is returned. Reads of other words do not raise it.
- R6: Reading an output-set or output-clear word returns zero and raises rsp_err for one cycle. Writing them raises no error.
- R7: The rising-enable words (0x030+4b, bank 3 at 0x130) and falling-enable words (0x03C+4b, bank 3 at 0x13C) are read/write and drive rise_en and fall_en.
- R8: A read of the edge-status word (0x048+4b, bank 3 at 0x148) returns that bank's slice of edge_status_in. A write to it places the data on that bank's slice of edge_clr for one cycle, starting the cycle after the write, with all other slices zero.
- R9: Each bank has a low alternate-function word at 0x054+8b and a high one at 0x058+8b, for b = 0..3. Both are read/write. The low word of bank b drives alt_sel[64b+31:64b] and the high word drives alt_sel[64b+63:64b+32].
- R10: Bank 3 registers other than the alternate-function words decode only at their +0x100 offsets and act on pins 96..127.
- R11: Any access to an offset below 0x200 that matches no register raises rsp_err for one cycle. A read of such an offset returns zero, and a write to it changes no state.
- R12: An access at offset 0x200 or above changes no state and raises no error. A read of such an offset returns zero.
- R13: Read data, rsp_err and rsp_valid appear one cycle after the request. rsp_valid is high only in the cycle after a read request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Bus request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte offset, word aligned |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid (cycle after a read) |
| rsp_rdata | output | 32 | Registered read data |
| rsp_err | output | 1 | One-cycle software access error |
| lvl_rd_pulse | output | 1 | One-cycle level-read notification |
| pad_in | input | 128 | Pin input levels |
| pad_out | output | 128 | Driven output levels (latch AND direction) |
| pad_oe | output | 128 | Output enables (direction) |
| rise_en | output | 128 | Rising-edge enables to the status block |
| fall_en | output | 128 | Falling-edge enables to the status block |
| edge_status_in | input | 128 | Edge status from the status block |
| edge_clr | output | 128 | One-cycle status clear mask |
| alt_sel | output | 256 | Alternate-function selects, two bits per pin |

## Verification
The checker watches, on every cycle, the properties that hold whatever the data is. A pin is never driven while its direction bit is clear. The response strobe follows read requests by exactly one cycle. An error always carries zero data, and a level pulse always comes with read data. A clear mask appears only after a write, output enables change only after a write, and accesses above the window never raise an error. The per-offset decode of the irregular map needs the bench's scenarios to show it: the bank-3 offsets, the merged level word, the read-back of every register kind, and the fact that an unmapped or out-of-window write leaves the registers untouched.

// File: rtl/gpio_regs_pkg.sv
package gpio_regs_pkg;

  localparam int unsigned BANKS  = 4;
  localparam int unsigned PINS_W = 32;

  typedef enum logic [3:0] {
    K_LVL  = 4'd0,
    K_DIR  = 4'd1,
    K_SET  = 4'd2,
    K_CLR  = 4'd3,
    K_RISE = 4'd4,
    K_FALL = 4'd5,
    K_EDGE = 4'd6,
    K_AFLO = 4'd7,
    K_AFHI = 4'd8,
    K_NONE = 4'd9
  } reg_kind_e;

  typedef struct packed {
    reg_kind_e  kind;
    logic [1:0] bank;
  } reg_sel_t;

  // Word index (offset / 4) within the 0x200 window to register kind and bank.
  // Seven kinds of three words each for banks 0..2, the same set repeated
  // from word 0x40 for bank 3, and eight alternate-function words at 0x15..0x1C.
  function automatic reg_sel_t decode_word(input logic [6:0] w);
    reg_sel_t   s;
    logic [6:0] rel;
    s.kind = K_NONE;
    s.bank = 2'd0;
    rel    = 7'd0;
    if (w < 7'd21) begin
      s.kind = reg_kind_e'(4'(w / 7'd3));
      s.bank = 2'(w % 7'd3);
    end else if (w <= 7'd28) begin
      rel    = w - 7'd21;
      s.kind = rel[0] ? K_AFHI : K_AFLO;
      s.bank = rel[2:1];
    end else if (w >= 7'd64 && w < 7'd85) begin
      rel = w - 7'd64;
      if ((rel % 7'd3) == 7'd0) begin
        s.kind = reg_kind_e'(4'(rel / 7'd3));
        s.bank = 2'd3;
      end
    end
    return s;
  endfunction

endpackage

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
  import gpio_regs_pkg::*;
#(
  parameter int unsigned ADDR_W = 12
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              in_window,
  output reg_sel_t          sel
);
  localparam int unsigned WIN_BYTES = 512;

  always_comb begin
    in_window = (addr < ADDR_W'(WIN_BYTES));
    sel       = decode_word(addr[8:2]);
    if (!in_window) begin
      sel.kind = K_NONE;
      sel.bank = 2'd0;
    end
  end
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_regs_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  reg_kind_e    kind,
  input  logic [W-1:0] wdata,
  input  logic [W-1:0] pin_in,
  output logic [W-1:0] dir_q,
  output logic [W-1:0] lat_q,
  output logic [W-1:0] rise_q,
  output logic [W-1:0] fall_q,
  output logic [W-1:0] aflo_q,
  output logic [W-1:0] afhi_q,
  output logic [W-1:0] in_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      dir_q  <= '0;
      lat_q  <= '0;
      rise_q <= '0;
      fall_q <= '0;
      aflo_q <= '0;
      afhi_q <= '0;
      in_q   <= '0;
    end else begin
      in_q <= pin_in;
      if (wr) begin
        unique case (kind)
          K_DIR:   dir_q  <= wdata;
          K_SET:   lat_q  <= lat_q | wdata;
          K_CLR:   lat_q  <= lat_q & ~wdata;
          K_RISE:  rise_q <= wdata;
          K_FALL:  fall_q <= wdata;
          K_AFLO:  aflo_q <= wdata;
          K_AFHI:  afhi_q <= wdata;
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/gpio_read_mux.sv
module gpio_read_mux
  import gpio_regs_pkg::*;
#(
  parameter int unsigned NB = 4,
  parameter int unsigned W  = 32
) (
  input  reg_sel_t          sel,
  input  logic              in_window,
  input  logic              is_read,
  input  logic [NB*W-1:0]   dir_v,
  input  logic [NB*W-1:0]   lat_v,
  input  logic [NB*W-1:0]   rise_v,
  input  logic [NB*W-1:0]   fall_v,
  input  logic [NB*W-1:0]   aflo_v,
  input  logic [NB*W-1:0]   afhi_v,
  input  logic [NB*W-1:0]   in_v,
  input  logic [NB*W-1:0]   stat_v,
  output logic [W-1:0]      rdata,
  output logic              err,
  output logic              lvl_hit
);
  logic [W-1:0] d, l, ri, fa, alo, ahi, iv, st;
  logic [$clog2(NB)-1:0] b;

  always_comb begin
    b   = sel.bank[$clog2(NB)-1:0];
    d   = dir_v[b*W +: W];
    l   = lat_v[b*W +: W];
    ri  = rise_v[b*W +: W];
    fa  = fall_v[b*W +: W];
    alo = aflo_v[b*W +: W];
    ahi = afhi_v[b*W +: W];
    iv  = in_v[b*W +: W];
    st  = stat_v[b*W +: W];

    rdata   = '0;
    lvl_hit = 1'b0;
    err     = in_window && (sel.kind == K_NONE);
    if (is_read) begin
      unique case (sel.kind)
        K_LVL: begin
          rdata   = (l & d) | (iv & ~d);
          lvl_hit = 1'b1;
        end
        K_DIR:   rdata = d;
        K_RISE:  rdata = ri;
        K_FALL:  rdata = fa;
        K_EDGE:  rdata = st;
        K_AFLO:  rdata = alo;
        K_AFHI:  rdata = ahi;
        K_SET, K_CLR: err = 1'b1;
        default: rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_regs_pkg::*;
#(
  parameter int unsigned NB     = BANKS,
  parameter int unsigned W      = PINS_W,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [W-1:0]      req_wdata,
  output logic              rsp_valid,
  output logic [W-1:0]      rsp_rdata,
  output logic              rsp_err,
  output logic              lvl_rd_pulse,
  input  logic [NB*W-1:0]   pad_in,
  output logic [NB*W-1:0]   pad_out,
  output logic [NB*W-1:0]   pad_oe,
  output logic [NB*W-1:0]   rise_en,
  output logic [NB*W-1:0]   fall_en,
  input  logic [NB*W-1:0]   edge_status_in,
  output logic [NB*W-1:0]   edge_clr,
  output logic [2*NB*W-1:0] alt_sel
);
  localparam int unsigned TOT = NB * W;

  logic     in_window;
  reg_sel_t sel;
  logic     is_read, is_write;

  logic [TOT-1:0] dir_v, lat_v, rise_v, fall_v, aflo_v, afhi_v, in_v;
  logic [W-1:0]   rdata_c;
  logic           err_c, lvl_c;

  assign is_read  = req_valid && !req_write;
  assign is_write = req_valid &&  req_write;

  gpio_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr      (req_addr),
    .in_window (in_window),
    .sel       (sel)
  );

  for (genvar b = 0; b < NB; b++) begin : g_bank
    logic bank_wr;
    assign bank_wr = is_write && in_window && (sel.kind != K_NONE) &&
                     (32'(sel.bank) == b);

    gpio_bank #(.W(W)) u_bank (
      .clk    (clk),
      .rst    (rst),
      .wr     (bank_wr),
      .kind   (sel.kind),
      .wdata  (req_wdata),
      .pin_in (pad_in[b*W +: W]),
      .dir_q  (dir_v[b*W +: W]),
      .lat_q  (lat_v[b*W +: W]),
      .rise_q (rise_v[b*W +: W]),
      .fall_q (fall_v[b*W +: W]),
      .aflo_q (aflo_v[b*W +: W]),
      .afhi_q (afhi_v[b*W +: W]),
      .in_q   (in_v[b*W +: W])
    );

    always_ff @(posedge clk) begin
      if (rst) edge_clr[b*W +: W] <= '0;
      else     edge_clr[b*W +: W] <= (bank_wr && sel.kind == K_EDGE) ? req_wdata : '0;
    end

    assign alt_sel[2*b*W +: W]     = aflo_v[b*W +: W];
    assign alt_sel[2*b*W + W +: W] = afhi_v[b*W +: W];
  end

  gpio_read_mux #(.NB(NB), .W(W)) u_rmux (
    .sel       (sel),
    .in_window (in_window),
    .is_read   (is_read),
    .dir_v     (dir_v),
    .lat_v     (lat_v),
    .rise_v    (rise_v),
    .fall_v    (fall_v),
    .aflo_v    (aflo_v),
    .afhi_v    (afhi_v),
    .in_v      (in_v),
    .stat_v    (edge_status_in),
    .rdata     (rdata_c),
    .err       (err_c),
    .lvl_hit   (lvl_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_valid    <= 1'b0;
      rsp_rdata    <= '0;
      rsp_err      <= 1'b0;
      lvl_rd_pulse <= 1'b0;
    end else begin
      rsp_valid    <= is_read;
      rsp_rdata    <= is_read ? rdata_c : '0;
      rsp_err      <= req_valid && err_c;
      lvl_rd_pulse <= is_read && lvl_c;
    end
  end

  assign pad_oe  = dir_v;
  assign pad_out = lat_v & dir_v;
  assign rise_en = rise_v;
  assign fall_en = fall_v;
endmodule

// File: rtl/gpio_bank_regs_chk.sv
module gpio_bank_regs_chk #(
  parameter int unsigned NB     = 4,
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 12
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_write,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_valid,
  input logic [W-1:0]      rsp_rdata,
  input logic              rsp_err,
  input logic              lvl_rd_pulse,
  input logic [NB*W-1:0]   pad_out,
  input logic [NB*W-1:0]   pad_oe,
  input logic [NB*W-1:0]   edge_clr
);
  localparam int unsigned WIN_BYTES = 512;

  // R3
  pad_masked_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_out & ~pad_oe) == '0);

  // R13
  rsp_follows_read_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write) |=> rsp_valid);

  // R13
  rsp_only_after_read_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && !req_write) |=> !rsp_valid);

  // R5
  lvl_with_data_chk: assert property (@(posedge clk) disable iff (rst)
    lvl_rd_pulse |-> rsp_valid);

  // R6
  err_zero_data_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_err |-> (rsp_rdata == '0));

  // R8
  clr_after_write_chk: assert property (@(posedge clk) disable iff (rst)
    (edge_clr != '0) |-> $past(req_valid && req_write));

  // R2
  oe_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !(req_valid && req_write) |=> $stable(pad_oe));

  // R12
  outside_no_err_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_addr >= ADDR_W'(WIN_BYTES)) |=> !rsp_err);
endmodule

bind gpio_bank_regs gpio_bank_regs_chk #(.NB(NB), .W(W), .ADDR_W(ADDR_W)) u_chk (
  .clk          (clk),
  .rst          (rst),
  .req_valid    (req_valid),
  .req_write    (req_write),
  .req_addr     (req_addr),
  .rsp_valid    (rsp_valid),
  .rsp_rdata    (rsp_rdata),
  .rsp_err      (rsp_err),
  .lvl_rd_pulse (lvl_rd_pulse),
  .pad_out      (pad_out),
  .pad_oe       (pad_oe),
  .edge_clr     (edge_clr)
);

// File: tb/gpio_bank_regs_test.sv
module gpio_bank_regs_test;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         req_valid = 1'b0, req_write = 1'b0;
  logic [11:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic         rsp_valid, rsp_err, lvl_rd_pulse;
  logic [31:0]  rsp_rdata;
  logic [127:0] pad_in, pad_out, pad_oe, rise_en, fall_en, edge_status_in, edge_clr;
  logic [255:0] alt_sel;

  int n_chk = 0, n_bad = 0;
  bit finished = 0;

  logic [31:0]  got_rd;
  logic         got_err, got_valid, got_lvl;
  logic [127:0] got_clr;

  always #4 clk = ~clk;

  gpio_bank_regs uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .lvl_rd_pulse(lvl_rd_pulse),
    .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe), .rise_en(rise_en),
    .fall_en(fall_en), .edge_status_in(edge_status_in), .edge_clr(edge_clr),
    .alt_sel(alt_sel)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] a;
    logic [31:0] d;
    logic [31:0] e;
    logic        er;
  } vec_t;

  localparam int NV = 27;
  localparam vec_t VEC [0:NV-1] = '{
    '{1'b1, 12'h00C, 32'h0000FFFF, 32'h0,        1'b0}, // R2 dir b0
    '{1'b0, 12'h00C, 32'h0,        32'h0000FFFF, 1'b0}, // R2
    '{1'b1, 12'h018, 32'h00FF00FF, 32'h0,        1'b0}, // R3 set, R6 no err on write
    '{1'b1, 12'h024, 32'h000000F0, 32'h0,        1'b0}, // R3 clear
    '{1'b0, 12'h000, 32'h0,        32'hA5A5000F, 1'b0}, // R4 merged level b0
    '{1'b0, 12'h018, 32'h0,        32'h0,        1'b1}, // R6
    '{1'b0, 12'h124, 32'h0,        32'h0,        1'b1}, // R6
    '{1'b1, 12'h130, 32'h12345678, 32'h0,        1'b0}, // R7 R10
    '{1'b0, 12'h130, 32'h0,        32'h12345678, 1'b0}, // R7
    '{1'b1, 12'h040, 32'hCAFEF00D, 32'h0,        1'b0}, // R7
    '{1'b0, 12'h040, 32'h0,        32'hCAFEF00D, 1'b0}, // R7
    '{1'b1, 12'h064, 32'h11112222, 32'h0,        1'b0}, // R9
    '{1'b0, 12'h064, 32'h0,        32'h11112222, 1'b0}, // R9
    '{1'b1, 12'h070, 32'h33334444, 32'h0,        1'b0}, // R9
    '{1'b0, 12'h070, 32'h0,        32'h33334444, 1'b0}, // R9
    '{1'b0, 12'h074, 32'h0,        32'h0,        1'b1}, // R11
    '{1'b0, 12'h104, 32'h0,        32'h0,        1'b1}, // R11
    '{1'b1, 12'h104, 32'hFFFFFFFF, 32'h0,        1'b1}, // R11
    '{1'b1, 12'h20C, 32'hFFFFFFFF, 32'h0,        1'b0}, // R12
    '{1'b0, 12'h00C, 32'h0,        32'h0000FFFF, 1'b0}, // R12 no alias
    '{1'b0, 12'h20C, 32'h0,        32'h0,        1'b0}, // R12
    '{1'b1, 12'h10C, 32'h80000001, 32'h0,        1'b0}, // R10
    '{1'b1, 12'h118, 32'hFFFFFFFF, 32'h0,        1'b0}, // R10
    '{1'b0, 12'h100, 32'h0,        32'h8000FFFF, 1'b0}, // R4 R10
    '{1'b0, 12'h10C, 32'h0,        32'h80000001, 1'b0}, // R10
    '{1'b0, 12'h054, 32'h0,        32'h0,        1'b0}, // R1 untouched AF word
    '{1'b0, 12'h004, 32'h0,        32'h13579BDF, 1'b0}  // R4 input-only bank
  };

  task automatic check(input string req, input logic [255:0] act, input logic [255:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic acc(input logic wr, input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    got_rd = rsp_rdata; got_err = rsp_err; got_valid = rsp_valid;
    got_lvl = lvl_rd_pulse; got_clr = edge_clr;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    pad_in         = {32'h0000FFFE, 32'h0, 32'h13579BDF, 32'hA5A55A5A};
    edge_status_in = {32'h0, 32'hDEAD0000, 64'h0};
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    check("R1 pad_oe", pad_oe, '0);
    check("R1 pad_out", pad_out, '0);
    check("R1 alt_sel", alt_sel, '0);
    check("R1 rise_en", rise_en, '0);
    acc(1'b0, 12'h130, 32'h0);
    check("R1 rise readback", got_rd, '0);

    for (int i = 0; i < NV; i++) begin
      acc(VEC[i].wr, VEC[i].a, VEC[i].d);
      if (!VEC[i].wr) check($sformatf("table %0d data", i), got_rd, VEC[i].e);
      check($sformatf("table %0d err", i), got_err, VEC[i].er);
    end

    // R3 pad outputs
    check("R3 pad_out b0", pad_out[31:0], 32'h0000000F);
    check("R2 pad_oe b0", pad_oe[31:0], 32'h0000FFFF);
    check("R10 pad_out b3", pad_out[127:96], 32'h80000001);
    check("R12 pad_oe b1 untouched", pad_oe[63:32], 32'h0);
    // R7 R9 outputs
    check("R7 rise_en b3", rise_en[127:96], 32'h12345678);
    check("R7 fall_en b1", fall_en[63:32], 32'hCAFEF00D);
    check("R9 alt_sel b2 low", alt_sel[159:128], 32'h11112222);
    check("R9 alt_sel b3 high", alt_sel[255:224], 32'h33334444);

    // R5 level notify
    acc(1'b0, 12'h000, 32'h0);
    check("R5 pulse on level read", got_lvl, 1'b1);
    check("R13 valid after read", got_valid, 1'b1);
    @(negedge clk);
    check("R5 pulse one cycle", lvl_rd_pulse, 1'b0);
    check("R13 valid one cycle", rsp_valid, 1'b0);
    acc(1'b0, 12'h00C, 32'h0);
    check("R5 no pulse on dir read", got_lvl, 1'b0);
    acc(1'b1, 12'h000, 32'h0);
    check("R13 no valid after write", got_valid, 1'b0);

    // R8 edge status
    acc(1'b0, 12'h050, 32'h0);
    check("R8 status read b2", got_rd, 32'hDEAD0000);
    acc(1'b1, 12'h148, 32'h00000F0F);
    check("R8 clear mask", got_clr, {32'h00000F0F, 96'h0});
    @(negedge clk);
    check("R8 clear one cycle", edge_clr, '0);

    // R1 reset mid-run
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 pad_oe after reset", pad_oe, '0);
    check("R1 pad_out after reset", pad_out, '0);
    acc(1'b0, 12'h070, 32'h0);
    check("R1 AF after reset", got_rd, '0);

    finish_run();
  end
endmodule